// File: doc/BRIEF.md
# Programmable Two-Phase Waveform Timer

This block is an 8-bit down-counting timer that drives one output pin with a waveform built from two alternating periods, called primary and secondary. Each period has its own reload register. The counter decrements once for each strobe on a count-tick input. When the counter sits at zero, the next tick loads the reload value of the other period, and the phase flips. Software uses a small write-only register port to set the run flag, the two-bit operating mode, the output level select and the two reload values.

The output level select sets the polarity in both phases. It also sets the level the pin holds while the timer is idle. Writes to a reload register behave differently depending on the run flag. While the timer runs, a write changes only the stored reload value. While it is stopped, the write also loads the counter, so the first primary period after a start uses the value just written. A one-clock pulse marks the end of every secondary period and can serve as an interrupt request.

Top module: `twp_timer`

## Requirements
- R1: After synchronous reset, all registers and the counter are zero and the phase is primary. `wave_out` is 0 and `period_done` is 0.
- R2: The waveform behaviour is enabled only when the run flag is 1 and the mode field equals binary 01. With any other mode value the counter holds and `wave_out` stays at the idle level.
- R3: While the run flag is 1, a write to a reload register changes only that reload register. The counter keeps counting undisturbed.
- R4: While the run flag is 0, a write to a reload register loads both that reload register and the counter.
- R5: With level select 0, `wave_out` is 1 in the primary phase and 0 in the secondary phase, and it is 0 while the timer is idle.
- R6: With level select 1, `wave_out` is 0 in the primary phase and 1 in the secondary phase, and it is 1 while the timer is idle.
- R7: On a tick with the counter at zero, the counter loads the other phase's reload value and the phase toggles. A reload value of N therefore gives a phase of N+1 ticks.
- R8: Counting begins in the primary phase when the run flag goes from 0 to 1. While the run flag is 0, the phase is forced back to primary.
- R9: A reload value written during a phase takes effect at the next reload of that phase and does not shorten the phase in progress.
- R10: `period_done` is 1 for exactly one clock, in the cycle after the tick that ends a secondary phase.
- R11: The counter changes only on cycles with `cnt_tick` high. Without a tick it holds its value.
- R12: Register map:
  - Address 0 is control: bit 0 is the run flag and bits 2:1 are the mode field.
  - Address 1 holds the level select in bit 0.
  - Address 2 is the primary reload.
  - Address 3 is the secondary reload.
  - All other control bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| cnt_tick | input | 1 | Count-source strobe, one decrement per high cycle |
| wave_out | output | 1 | Waveform output |
| period_done | output | 1 | One-clock pulse at the end of each secondary period |

## Verification
A corrupted counter or a reload taken from the wrong register shows up at `wave_out` as an edge that comes too early or too late. That edge is visible within one phase length, at most 256 ticks. A phase flag that is stuck or not cleared on stop shows up as inverted polarity, or as a missing or misplaced `period_done` pulse, on the first clock of the next phase or start. A wrong write routing appears as a first primary period after a start whose length differs from the value written while stopped.

// File: rtl/twp_pkg.sv
package twp_pkg;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 2;
    localparam int MODE_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_LVL  = 2'd1;
    localparam logic [ADDR_W-1:0] A_PRI  = 2'd2;
    localparam logic [ADDR_W-1:0] A_SEC  = 2'd3;

    localparam logic [MODE_W-1:0] MODE_WAVE = 2'b01;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        PH_PRI = 1'b0,
        PH_SEC = 1'b1
    } phase_e;

    typedef struct packed {
        logic              run;
        logic [MODE_W-1:0] mode;
        logic              lvl;
        cnt_t              pri_rl;
        cnt_t              sec_rl;
    } cfg_t;

    // Level on the pin for a given state; idle level equals the select bit.
    function automatic logic wave_level(logic active, phase_e ph, logic lvl);
        if (!active)
            return lvl;
        return (ph == PH_PRI) ? ~lvl : lvl;
    endfunction

    // Reload value taken when the current phase ends.
    function automatic cnt_t next_reload(phase_e ph, cnt_t pri, cnt_t sec);
        return (ph == PH_PRI) ? sec : pri;
    endfunction

endpackage

// File: rtl/twp_regs.sv
module twp_regs
    import twp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  cnt_t              bus_wdata,
    output cfg_t              cfg,
    output logic              load_en,
    output cnt_t              load_val
);

    logic is_reload;

    assign is_reload = (bus_addr == A_PRI) || (bus_addr == A_SEC);
    // Stopped-state writes to a reload register go to the counter as well.
    assign load_en   = bus_we && is_reload && !cfg.run;
    assign load_val  = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_CTRL: begin
                    cfg.run  <= bus_wdata[0];
                    cfg.mode <= bus_wdata[MODE_W:1];
                end
                A_LVL:   cfg.lvl    <= bus_wdata[0];
                A_PRI:   cfg.pri_rl <= bus_wdata;
                default: cfg.sec_rl <= bus_wdata;
            endcase
        end
    end

endmodule

// File: rtl/twp_core.sv
module twp_core
    import twp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   active,
    input  logic   tick,
    input  logic   load_en,
    input  cnt_t   load_val,
    input  cnt_t   pri_rl,
    input  cnt_t   sec_rl,
    output cnt_t   cnt,
    output phase_e phase,
    output logic   done
);

    logic at_zero;
    logic step;

    assign at_zero = (cnt == '0);
    assign step    = active && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= PH_PRI;
            done  <= 1'b0;
        end else begin
            done <= step && at_zero && (phase == PH_SEC);
            if (load_en) begin
                cnt <= load_val;
            end else if (step) begin
                if (at_zero) begin
                    cnt   <= next_reload(phase, pri_rl, sec_rl);
                    phase <= (phase == PH_PRI) ? PH_SEC : PH_PRI;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
            if (!run)
                phase <= PH_PRI;
        end
    end

endmodule

// File: rtl/twp_outdrv.sv
module twp_outdrv
    import twp_pkg::*;
(
    input  logic   active,
    input  phase_e phase,
    input  logic   lvl,
    output logic   wave
);

    assign wave = wave_level(active, phase, lvl);

endmodule

// File: rtl/twp_timer.sv
module twp_timer
    import twp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       cnt_tick,
    output logic       wave_out,
    output logic       period_done
);

    cfg_t   cfg;
    logic   load_en;
    cnt_t   load_val;
    cnt_t   cnt;
    phase_e phase;
    logic   active;

    assign active = cfg.run && (cfg.mode == MODE_WAVE);

    twp_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .cfg      (cfg),
        .load_en  (load_en),
        .load_val (load_val)
    );

    twp_core u_core (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg.run),
        .active  (active),
        .tick    (cnt_tick),
        .load_en (load_en),
        .load_val(load_val),
        .pri_rl  (cfg.pri_rl),
        .sec_rl  (cfg.sec_rl),
        .cnt     (cnt),
        .phase   (phase),
        .done    (period_done)
    );

    twp_outdrv u_out (
        .active(active),
        .phase (phase),
        .lvl   (cfg.lvl),
        .wave  (wave_out)
    );

endmodule

// File: rtl/twp_timer_chk.sv
module twp_timer_chk
    import twp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_we,
    input logic [1:0] bus_addr,
    input logic       cnt_tick,
    input logic       wave_out,
    input logic       period_done,
    input logic       run,
    input logic       active,
    input logic       lvl,
    input cnt_t       cnt,
    input phase_e     phase,
    input cnt_t       pri_rl,
    input cnt_t       sec_rl
);

    p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
        !active |-> (wave_out == lvl));

    p_mode_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !active) |=> $stable(cnt));

    p_run_write_r3: assert property (@(posedge clk) disable iff (rst)
        (active && bus_we && bus_addr[1] && cnt_tick && cnt != '0)
        |=> (cnt == $past(cnt) - 1'b1));

    p_alternate_r7: assert property (@(posedge clk) disable iff (rst)
        (active && cnt_tick && cnt == '0 && !(bus_we && bus_addr == A_CTRL))
        |=> (phase != $past(phase)) &&
            (cnt == (($past(phase) == PH_PRI) ? $past(sec_rl) : $past(pri_rl))));

    p_stop_primary_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == PH_PRI));

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        period_done |=> !period_done);

    p_pulse_origin_r10: assert property (@(posedge clk) disable iff (rst)
        period_done |-> ($past(phase) == PH_SEC) && (phase == PH_PRI));

    p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_tick) |=> $stable(cnt));

endmodule

bind twp_timer twp_timer_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .cnt_tick   (cnt_tick),
    .wave_out   (wave_out),
    .period_done(period_done),
    .run        (cfg.run),
    .active     (active),
    .lvl        (cfg.lvl),
    .cnt        (cnt),
    .phase      (phase),
    .pri_rl     (cfg.pri_rl),
    .sec_rl     (cfg.sec_rl)
);

// File: tb/twp_timer_tb.sv
`timescale 1ns/1ps
module twp_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       cnt_tick = 1'b0;
    logic       wave_out;
    logic       period_done;

    int    n_checks = 0;
    int    n_fails  = 0;
    string focus    = "R1";

    // Reference state, from the requirements.
    bit       m_run, m_lvl, m_ph, m_done;
    bit [1:0] m_mode;
    bit [7:0] m_pri, m_sec, m_cnt;

    always #4 clk = ~clk;

    twp_timer dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt_tick   (cnt_tick),
        .wave_out   (wave_out),
        .period_done(period_done)
    );

    function automatic bit exp_wave();
        bit act = m_run && (m_mode == 2'b01);
        if (!act) return m_lvl;
        return m_ph ? m_lvl : ~m_lvl;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_run = 0; m_lvl = 0; m_ph = 0; m_done = 0;
        m_mode = 0; m_pri = 0; m_sec = 0; m_cnt = 0;
    endtask

    task automatic model_step(bit we, bit [1:0] a, bit [7:0] d, bit tk);
        bit act = m_run && (m_mode == 2'b01);
        m_done = 0;
        if (we && !m_run && a[1]) begin
            m_cnt = d;                               // R4
        end else if (act && tk) begin
            if (m_cnt == 0) begin                    // R7
                m_done = m_ph;                       // R10
                m_cnt  = m_ph ? m_pri : m_sec;
                m_ph   = ~m_ph;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        if (!m_run) m_ph = 0;                        // R8
        if (we) begin
            case (a)
                2'd0: begin m_run = d[0]; m_mode = d[2:1]; end
                2'd1: m_lvl = d[0];
                2'd2: m_pri = d;
                default: m_sec = d;
            endcase
        end
    endtask

    task automatic compare();
        string wtag;
        if (focus == "R7" && !(m_run && m_mode == 2'b01))
            wtag = m_lvl ? "R6" : "R5";
        else
            wtag = focus;
        check(wave_out == exp_wave(), wtag, int'(wave_out), int'(exp_wave()));
        check(period_done == m_done, "R10", int'(period_done), int'(m_done));
    endtask

    task automatic cyc(bit we, bit [1:0] a, bit [7:0] d, bit tk);
        @(negedge clk);
        compare();
        bus_we = we; bus_addr = a; bus_wdata = d; cnt_tick = tk;
        @(posedge clk);
        model_step(we, a, d, tk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(0, 2'd0, 8'd0, 1'b1);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 2'd0, 8'd0, 1'b0);
    endtask

    initial begin
        #(200000 * 8);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // r1_: reset values, then zero reloads alternate each tick
        focus = "R1";
        check(wave_out == 1'b0, "R1", int'(wave_out), 0);
        check(period_done == 1'b0, "R1", int'(period_done), 0);
        idle(2);
        cyc(1, 2'd0, 8'h03, 1'b0);
        ticks(4);
        cyc(1, 2'd0, 8'h00, 1'b0);
        // r4_: stopped writes load the counter
        focus = "R4";
        cyc(1, 2'd3, 8'd1, 1'b0);
        cyc(1, 2'd2, 8'd2, 1'b0);
        focus = "R8";
        cyc(1, 2'd0, 8'h03, 1'b0);
        focus = "R5";
        ticks(12);
        focus = "R11";
        idle(5);
        ticks(2);
        focus = "R3";
        cyc(1, 2'd2, 8'd4, 1'b1);
        ticks(10);
        focus = "R9";
        cyc(1, 2'd3, 8'd3, 1'b0);
        ticks(15);
        focus = "R8";
        cyc(1, 2'd0, 8'h00, 1'b1);
        idle(3);
        cyc(1, 2'd0, 8'h03, 1'b1);
        ticks(6);
        focus = "R6";
        cyc(1, 2'd1, 8'h01, 1'b1);
        ticks(10);
        cyc(1, 2'd0, 8'h00, 1'b0);
        idle(2);
        focus = "R2";
        cyc(1, 2'd0, 8'h05, 1'b1);
        ticks(6);
        cyc(1, 2'd0, 8'h07, 1'b1);
        ticks(6);
        cyc(1, 2'd0, 8'h00, 1'b0);
        focus = "R12";
        cyc(1, 2'd0, 8'hF8, 1'b1);
        ticks(3);
        cyc(1, 2'd1, 8'h00, 1'b0);
        focus = "R10";
        cyc(1, 2'd2, 8'd0, 1'b0);
        cyc(1, 2'd3, 8'd0, 1'b0);
        cyc(1, 2'd0, 8'h03, 1'b0);
        ticks(8);
        // Random mix
        focus = "R7";
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom % 100;
            bit tk = 1'($urandom % 2);
            if (r < 6)
                cyc(1, 2'd2 + 2'($urandom % 2), 8'($urandom % 5), tk);
            else if (r < 8)
                cyc(1, 2'd0, {5'd0, (($urandom % 100) < 80) ? 2'b01 : 2'($urandom), 1'($urandom)}, tk);
            else if (r < 9)
                cyc(1, 2'd1, 8'($urandom), tk);
            else
                cyc(0, 2'd0, 8'd0, tk);
        end
        @(negedge clk);
        compare();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule